// File: doc/BRIEF.md
# Trap entry state save unit

This block carries out the architectural bookkeeping at the moment a processor takes a trap. On a one-cycle take strobe it reads the trap type, the requested handler mode (privileged or hyperprivileged) and a flag that forces entry into the reset/error (RED) state. It also reads the live machine state: trap level, global register level, condition codes, address space identifier, processor-state and hyper-state words, current window pointer, the count of saveable windows, and the two program counters. In that single cycle it pushes one entry onto a trap stack, and it produces the new trap level, global level, processor-state, hyper-state and window pointer.

Each trap stack entry holds five things. The first is a packed state word. The second and third are the saved PC and NPC, cut to 32 bits when the processor-state address-mask bit is set. The fourth is a copy of the hyper-state word as it was before the trap. The fifth is the trap type. Entries are indexed by trap level 1..MAXTL and can be read back through a combinational read port. The new-state outputs are registered and hold their value until the next trap. A done pulse marks the cycle in which they become valid. Vector address generation is left to the surrounding logic.

Top module: `trap_entry_unit`

## Requirements
- R1: A take strobe with level input L (L < MAXTL) makes `tl_o` equal L+1 and raises `done_o` for exactly one cycle, both on the clock edge that samples the strobe. Without a strobe, all new-state outputs hold their value.
- R2: The strobe writes the stack entry at level L+1, and no other level changes. Its state word carries the global level zero-extended in bits 42:40, the condition codes in 39:32, the ASI in 31:24, the incoming processor-state in 20:8 and the window pointer zero-extended in 4:0. All other bits are zero. The entry also stores the 9-bit trap type.
- R3: Saved PC and NPC keep all 64 bits when processor-state bit 3 (address mask) is 0. When that bit is 1, their upper 32 bits are cleared.
- R4: The stored hyper-state copy equals the hyper-state input before any modification.
- R5: The new global level is min(GL+1, MAXGL=3) on hyperprivileged or RED entry, and min(GL+1, MAXPGL=2) on privileged entry.
- R6: On non-RED entry, processor-state bit 4 (fp enable) is set and bits 3 (address mask) and 1 (interrupt enable) are cleared. Bits 7:6 (memory model), bit 8 (trap little-endian) and bit 12 are kept.
- R7: On hyperprivileged entry (`to_hyper_i`=1, `red_i`=0), processor-state bit 9 (current little-endian) is cleared and bit 2 (priv) is kept. In hyper-state, bit 5 (red) is cleared, bit 2 (hpriv) is set, bit 10 (instruction break enable) is cleared, and bit 0 (tl-zero trap enable) and the other bits are kept.
- R8: On privileged entry (`to_hyper_i`=0, `red_i`=0), processor-state bit 2 is set and bit 9 takes the value of incoming bit 8. Hyper-state is unchanged.
- R9: On RED entry (`red_i`=1, which overrides `to_hyper_i`), processor-state becomes zero except that bit 2 keeps its old value and bit 4 is set. In hyper-state, bits 5 and 2 are set, bits 10 and 0 are cleared, and the other bits are kept.
- R10: The window pointer is adjusted by trap type: type 0x024 adds 1, types 0x080..0x0BF add CANSAVE+2, types 0x0C0..0x0FF subtract 1, and every other 9-bit type leaves it unchanged. The result wraps modulo NWIN=8.
- R11: After reset, all outputs are zero and every stack level reads as zero. The read port returns the entry selected by `rd_lvl_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| take_i | input | 1 | Take-trap strobe, one cycle per trap |
| ttype_i | input | 9 | Trap type |
| to_hyper_i | input | 1 | 1 = hyperprivileged handler, 0 = privileged handler |
| red_i | input | 1 | Force RED-state entry |
| tl_i | input | 3 | Current trap level |
| gl_i | input | 2 | Current global register level |
| ccr_i | input | 8 | Condition codes |
| asi_i | input | 8 | Current address space identifier |
| pstate_i | input | 13 | Current processor-state word |
| hstate_i | input | 12 | Current hyper-state word |
| cwp_i | input | 3 | Current window pointer |
| cansave_i | input | 3 | Saveable window count |
| pc_i | input | 64 | Program counter |
| npc_i | input | 64 | Next program counter |
| done_o | output | 1 | One-cycle pulse when the new state is valid |
| tl_o | output | 3 | New trap level |
| gl_o | output | 2 | New global level |
| pstate_o | output | 13 | New processor-state word |
| hstate_o | output | 12 | New hyper-state word |
| cwp_o | output | 3 | New window pointer |
| rd_lvl_i | input | 3 | Trap stack read level |
| rd_tstate_o | output | 43 | Packed state word at the read level |
| rd_tpc_o | output | 64 | Saved PC at the read level |
| rd_tnpc_o | output | 64 | Saved NPC at the read level |
| rd_htstate_o | output | 12 | Saved hyper-state at the read level |
| rd_tt_o | output | 9 | Saved trap type at the read level |

## Verification
The hardest situation to reach is the window adjustment for spill types when CANSAVE and the current window are both high. In that case the sum runs past twice the window count minus one and must wrap correctly. The stimulus reaches it with directed cases at the top of the range, and also with random traps whose type is drawn by class so the spill, fill and clean-window ranges come up often. Further directed cases probe type codes whose low byte matches a window-moving code but whose ninth bit is set. Other directed cases cover global-level saturation from a level already at the cap, and a trap taken from the highest legal level, after which the whole stack is read back to show that only one level changed.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;
   localparam int TT_W   = 9;
   localparam int CCR_W  = 8;
   localparam int ASI_W  = 8;
   localparam int PS_W   = 13;
   localparam int HS_W   = 12;
   localparam int TSW_W  = 43;

   // packed state word field positions (decoded by the return path)
   localparam int TS_GL_LO  = 40;
   localparam int TS_GL_W   = 3;
   localparam int TS_CCR_LO = 32;
   localparam int TS_ASI_LO = 24;
   localparam int TS_PS_LO  = 8;
   localparam int TS_CWP_LO = 0;
   localparam int TS_CWP_W  = 5;

   // processor-state bit positions
   localparam int PS_IE   = 1;
   localparam int PS_PRIV = 2;
   localparam int PS_AM   = 3;
   localparam int PS_PEF  = 4;
   localparam int PS_TLE  = 8;
   localparam int PS_CLE  = 9;

   // hyper-state bit positions
   localparam int HS_TLZ   = 0;
   localparam int HS_HPRIV = 2;
   localparam int HS_RED   = 5;
   localparam int HS_IBE   = 10;

   typedef enum logic [1:0] {
      ENTRY_PRIV  = 2'd0,
      ENTRY_HYPER = 2'd1,
      ENTRY_RED   = 2'd2
   } entry_kind_t;
endpackage

// File: rtl/tse_state_pack.sv
module tse_state_pack
   import trap_entry_pkg::*;
#(
   parameter int GL_W  = 2,
   parameter int CWP_W = 3,
   parameter int PC_W  = 64
) (
   input  logic [GL_W-1:0]  gl_i,
   input  logic [CCR_W-1:0] ccr_i,
   input  logic [ASI_W-1:0] asi_i,
   input  logic [PS_W-1:0]  pstate_i,
   input  logic [CWP_W-1:0] cwp_i,
   input  logic [PC_W-1:0]  pc_i,
   input  logic [PC_W-1:0]  npc_i,
   output logic [TSW_W-1:0] tstate_o,
   output logic [PC_W-1:0]  tpc_o,
   output logic [PC_W-1:0]  tnpc_o
);
   always_comb begin
      tstate_o = '0;
      tstate_o[TS_GL_LO  +: TS_GL_W]  = TS_GL_W'(gl_i);
      tstate_o[TS_CCR_LO +: CCR_W]    = ccr_i;
      tstate_o[TS_ASI_LO +: ASI_W]    = asi_i;
      tstate_o[TS_PS_LO  +: PS_W]     = pstate_i;
      tstate_o[TS_CWP_LO +: TS_CWP_W] = TS_CWP_W'(cwp_i);
   end

   generate
      if (PC_W > 32) begin : g_mask
         logic [PC_W-1:0] keep;
         assign keep   = pstate_i[PS_AM] ? {{(PC_W-32){1'b0}}, {32{1'b1}}} : '1;
         assign tpc_o  = pc_i  & keep;
         assign tnpc_o = npc_i & keep;
      end else begin : g_nomask
         assign tpc_o  = pc_i;
         assign tnpc_o = npc_i;
      end
   endgenerate
endmodule

// File: rtl/tse_mode_update.sv
module tse_mode_update
   import trap_entry_pkg::*;
#(
   parameter int GL_W   = 2,
   parameter int MAXGL  = 3,
   parameter int MAXPGL = 2
) (
   input  entry_kind_t      kind_i,
   input  logic [GL_W-1:0]  gl_i,
   input  logic [PS_W-1:0]  pstate_i,
   input  logic [HS_W-1:0]  hstate_i,
   output logic [GL_W-1:0]  gl_o,
   output logic [PS_W-1:0]  pstate_o,
   output logic [HS_W-1:0]  hstate_o
);
   localparam logic [GL_W:0] CAP_H = (GL_W+1)'(MAXGL);
   localparam logic [GL_W:0] CAP_P = (GL_W+1)'(MAXPGL);

   logic [GL_W:0] gl_inc;
   logic [GL_W:0] cap;

   always_comb begin
      gl_inc = {1'b0, gl_i} + 1'b1;
      cap    = (kind_i == ENTRY_PRIV) ? CAP_P : CAP_H;
      gl_o   = (gl_inc > cap) ? cap[GL_W-1:0] : gl_inc[GL_W-1:0];
   end

   always_comb begin
      pstate_o = pstate_i;
      hstate_o = hstate_i;
      unique case (kind_i)
         ENTRY_RED: begin
            pstate_o          = '0;
            pstate_o[PS_PRIV] = pstate_i[PS_PRIV];
            pstate_o[PS_PEF]  = 1'b1;
            hstate_o[HS_RED]   = 1'b1;
            hstate_o[HS_HPRIV] = 1'b1;
            hstate_o[HS_IBE]   = 1'b0;
            hstate_o[HS_TLZ]   = 1'b0;
         end
         ENTRY_HYPER: begin
            pstate_o[PS_PEF] = 1'b1;
            pstate_o[PS_AM]  = 1'b0;
            pstate_o[PS_IE]  = 1'b0;
            pstate_o[PS_CLE] = 1'b0;
            hstate_o[HS_RED]   = 1'b0;
            hstate_o[HS_HPRIV] = 1'b1;
            hstate_o[HS_IBE]   = 1'b0;
         end
         default: begin
            pstate_o[PS_PEF]  = 1'b1;
            pstate_o[PS_AM]   = 1'b0;
            pstate_o[PS_IE]   = 1'b0;
            pstate_o[PS_PRIV] = 1'b1;
            pstate_o[PS_CLE]  = pstate_i[PS_TLE];
         end
      endcase
   end
endmodule

// File: rtl/tse_window_adjust.sv
module tse_window_adjust
   import trap_entry_pkg::*;
#(
   parameter int NWIN  = 8,
   parameter int CWP_W = 3
) (
   input  logic [TT_W-1:0]  ttype_i,
   input  logic [CWP_W-1:0] cwp_i,
   input  logic [CWP_W-1:0] cansave_i,
   output logic [CWP_W-1:0] cwp_o
);
   localparam int SUM_W = CWP_W + 2;
   localparam logic [SUM_W-1:0] NW   = SUM_W'(NWIN);
   localparam logic [CWP_W-1:0] TOPW = CWP_W'(NWIN - 1);

   logic is_clean, is_spill, is_fill;
   logic [CWP_W-1:0] w_inc, w_dec, w_spill;
   logic [SUM_W-1:0] s0;

   assign is_clean = (ttype_i == 9'h024);
   assign is_spill = (ttype_i >= 9'h080) && (ttype_i <= 9'h0BF);
   assign is_fill  = (ttype_i >= 9'h0C0) && (ttype_i <= 9'h0FF);

   assign w_inc = (cwp_i == TOPW) ? '0 : cwp_i + 1'b1;
   assign w_dec = (cwp_i == '0) ? TOPW : cwp_i - 1'b1;
   assign s0    = SUM_W'(cwp_i) + SUM_W'(cansave_i) + SUM_W'(2);

   generate
      if ((NWIN & (NWIN - 1)) == 0) begin : g_pow2
         assign w_spill = s0[CWP_W-1:0];
      end else begin : g_general
         logic [SUM_W-1:0] s1, s2;
         assign s1      = (s0 >= NW) ? s0 - NW : s0;
         assign s2      = (s1 >= NW) ? s1 - NW : s1;
         assign w_spill = s2[CWP_W-1:0];
      end
   endgenerate

   always_comb begin
      if (is_clean)      cwp_o = w_inc;
      else if (is_spill) cwp_o = w_spill;
      else if (is_fill)  cwp_o = w_dec;
      else               cwp_o = cwp_i;
   end
endmodule

// File: rtl/tse_trap_stack.sv
module tse_trap_stack
   import trap_entry_pkg::*;
#(
   parameter int DEPTH = 6,
   parameter int LVL_W = 3,
   parameter int PC_W  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [LVL_W-1:0]  wlvl_i,
   input  logic [TSW_W-1:0]  tstate_i,
   input  logic [PC_W-1:0]   tpc_i,
   input  logic [PC_W-1:0]   tnpc_i,
   input  logic [HS_W-1:0]   htstate_i,
   input  logic [TT_W-1:0]   tt_i,
   input  logic [LVL_W-1:0]  rlvl_i,
   output logic [TSW_W-1:0]  tstate_o,
   output logic [PC_W-1:0]   tpc_o,
   output logic [PC_W-1:0]   tnpc_o,
   output logic [HS_W-1:0]   htstate_o,
   output logic [TT_W-1:0]   tt_o
);
   logic [TSW_W-1:0] ts_w [0:DEPTH];
   logic [PC_W-1:0]  pc_w [0:DEPTH];
   logic [PC_W-1:0]  np_w [0:DEPTH];
   logic [HS_W-1:0]  hs_w [0:DEPTH];
   logic [TT_W-1:0]  tt_w [0:DEPTH];

   assign ts_w[0] = '0;
   assign pc_w[0] = '0;
   assign np_w[0] = '0;
   assign hs_w[0] = '0;
   assign tt_w[0] = '0;

   generate
      for (genvar l = 1; l <= DEPTH; l++) begin : g_lvl
         logic [TSW_W-1:0] ts_q;
         logic [PC_W-1:0]  pc_q, np_q;
         logic [HS_W-1:0]  hs_q;
         logic [TT_W-1:0]  tt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ts_q <= '0;
               pc_q <= '0;
               np_q <= '0;
               hs_q <= '0;
               tt_q <= '0;
            end else if (we_i && (wlvl_i == LVL_W'(l))) begin
               ts_q <= tstate_i;
               pc_q <= tpc_i;
               np_q <= tnpc_i;
               hs_q <= htstate_i;
               tt_q <= tt_i;
            end
         end
         assign ts_w[l] = ts_q;
         assign pc_w[l] = pc_q;
         assign np_w[l] = np_q;
         assign hs_w[l] = hs_q;
         assign tt_w[l] = tt_q;
      end
   endgenerate

   logic rd_ok;
   assign rd_ok = (32'(rlvl_i) <= DEPTH);

   always_comb begin
      tstate_o  = '0;
      tpc_o     = '0;
      tnpc_o    = '0;
      htstate_o = '0;
      tt_o      = '0;
      for (int l = 0; l <= DEPTH; l++) begin
         if (rd_ok && (rlvl_i == LVL_W'(l))) begin
            tstate_o  = ts_w[l];
            tpc_o     = pc_w[l];
            tnpc_o    = np_w[l];
            htstate_o = hs_w[l];
            tt_o      = tt_w[l];
         end
      end
   end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
   import trap_entry_pkg::*;
#(
   parameter int NWIN   = 8,
   parameter int MAXTL  = 6,
   parameter int MAXGL  = 3,
   parameter int MAXPGL = 2,
   parameter int PC_W   = 64,
   localparam int TL_W  = $clog2(MAXTL + 1),
   localparam int GL_W  = $clog2(MAXGL + 1),
   localparam int CWP_W = $clog2(NWIN)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               take_i,
   input  logic [TT_W-1:0]    ttype_i,
   input  logic               to_hyper_i,
   input  logic               red_i,
   input  logic [TL_W-1:0]    tl_i,
   input  logic [GL_W-1:0]    gl_i,
   input  logic [CCR_W-1:0]   ccr_i,
   input  logic [ASI_W-1:0]   asi_i,
   input  logic [PS_W-1:0]    pstate_i,
   input  logic [HS_W-1:0]    hstate_i,
   input  logic [CWP_W-1:0]   cwp_i,
   input  logic [CWP_W-1:0]   cansave_i,
   input  logic [PC_W-1:0]    pc_i,
   input  logic [PC_W-1:0]    npc_i,
   output logic               done_o,
   output logic [TL_W-1:0]    tl_o,
   output logic [GL_W-1:0]    gl_o,
   output logic [PS_W-1:0]    pstate_o,
   output logic [HS_W-1:0]    hstate_o,
   output logic [CWP_W-1:0]   cwp_o,
   input  logic [TL_W-1:0]    rd_lvl_i,
   output logic [TSW_W-1:0]   rd_tstate_o,
   output logic [PC_W-1:0]    rd_tpc_o,
   output logic [PC_W-1:0]    rd_tnpc_o,
   output logic [HS_W-1:0]    rd_htstate_o,
   output logic [TT_W-1:0]    rd_tt_o
);
   // elaboration-time parameter checks
   generate
      if (NWIN < 2 || NWIN > 32) begin : g_bad_nwin
         $error("NWIN must lie in 2..32 to fit the 5-bit window field");
      end
      if (MAXGL < 1 || MAXGL > 7) begin : g_bad_gl
         $error("MAXGL must lie in 1..7 to fit the 3-bit global field");
      end
      if (MAXPGL < 1 || MAXPGL > MAXGL) begin : g_bad_pgl
         $error("MAXPGL must lie in 1..MAXGL");
      end
      if (MAXTL < 1) begin : g_bad_tl
         $error("MAXTL must be at least 1");
      end
      if (PC_W < 32) begin : g_bad_pc
         $error("PC_W must be at least 32");
      end
   endgenerate

   entry_kind_t      kind;
   logic [TL_W-1:0]  new_lvl;
   logic             lvl_ok;
   logic [TSW_W-1:0] ts_n;
   logic [PC_W-1:0]  tpc_n, tnpc_n;
   logic [GL_W-1:0]  gl_n;
   logic [PS_W-1:0]  ps_n;
   logic [HS_W-1:0]  hs_n;
   logic [CWP_W-1:0] cwp_n;

   assign kind    = red_i ? ENTRY_RED : (to_hyper_i ? ENTRY_HYPER : ENTRY_PRIV);
   assign lvl_ok  = (32'(tl_i) < MAXTL);
   assign new_lvl = tl_i + 1'b1;

   tse_state_pack #(.GL_W(GL_W), .CWP_W(CWP_W), .PC_W(PC_W)) u_pack (
      .gl_i(gl_i), .ccr_i(ccr_i), .asi_i(asi_i), .pstate_i(pstate_i),
      .cwp_i(cwp_i), .pc_i(pc_i), .npc_i(npc_i),
      .tstate_o(ts_n), .tpc_o(tpc_n), .tnpc_o(tnpc_n)
   );

   tse_mode_update #(.GL_W(GL_W), .MAXGL(MAXGL), .MAXPGL(MAXPGL)) u_mode (
      .kind_i(kind), .gl_i(gl_i), .pstate_i(pstate_i), .hstate_i(hstate_i),
      .gl_o(gl_n), .pstate_o(ps_n), .hstate_o(hs_n)
   );

   tse_window_adjust #(.NWIN(NWIN), .CWP_W(CWP_W)) u_win (
      .ttype_i(ttype_i), .cwp_i(cwp_i), .cansave_i(cansave_i), .cwp_o(cwp_n)
   );

   tse_trap_stack #(.DEPTH(MAXTL), .LVL_W(TL_W), .PC_W(PC_W)) u_stack (
      .clk(clk), .rst_n(rst_n),
      .we_i(take_i && lvl_ok), .wlvl_i(new_lvl),
      .tstate_i(ts_n), .tpc_i(tpc_n), .tnpc_i(tnpc_n),
      .htstate_i(hstate_i), .tt_i(ttype_i),
      .rlvl_i(rd_lvl_i),
      .tstate_o(rd_tstate_o), .tpc_o(rd_tpc_o), .tnpc_o(rd_tnpc_o),
      .htstate_o(rd_htstate_o), .tt_o(rd_tt_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o   <= 1'b0;
         tl_o     <= '0;
         gl_o     <= '0;
         pstate_o <= '0;
         hstate_o <= '0;
         cwp_o    <= '0;
      end else begin
         done_o <= take_i;
         if (take_i) begin
            tl_o     <= lvl_ok ? new_lvl : tl_i;
            gl_o     <= gl_n;
            pstate_o <= ps_n;
            hstate_o <= hs_n;
            cwp_o    <= cwp_n;
         end
      end
   end
endmodule

// File: rtl/trap_entry_unit_chk.sv
module trap_entry_unit_chk
   import trap_entry_pkg::*;
#(
   parameter int NWIN   = 8,
   parameter int MAXTL  = 6,
   parameter int MAXGL  = 3,
   parameter int MAXPGL = 2,
   localparam int TL_W  = $clog2(MAXTL + 1),
   localparam int GL_W  = $clog2(MAXGL + 1),
   localparam int CWP_W = $clog2(NWIN)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             take_i,
   input logic             to_hyper_i,
   input logic             red_i,
   input logic [TL_W-1:0]  tl_i,
   input logic             done_o,
   input logic [TL_W-1:0]  tl_o,
   input logic [GL_W-1:0]  gl_o,
   input logic [PS_W-1:0]  pstate_o,
   input logic [HS_W-1:0]  hstate_o,
   input logic [CWP_W-1:0] cwp_o
);
   p_level_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && (32'(tl_i) < MAXTL)) |=> (tl_o == TL_W'($past(tl_i) + 1'b1)));

   p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |=> done_o);

   p_done_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !take_i |=> (!done_o && $stable(tl_o) && $stable(pstate_o) && $stable(cwp_o)));

   p_gl_priv_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && !to_hyper_i && !red_i) |=> (32'(gl_o) <= MAXPGL));

   p_gl_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (32'(gl_o) <= MAXGL));

   p_fp_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      take_i |=> pstate_o[PS_PEF]);

   p_hyper_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && to_hyper_i && !red_i) |=> (hstate_o[HS_HPRIV] && !hstate_o[HS_RED] && !pstate_o[PS_CLE]));

   p_priv_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && !to_hyper_i && !red_i) |=> pstate_o[PS_PRIV]);

   p_red_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && red_i) |=> (hstate_o[HS_RED] && hstate_o[HS_HPRIV] && !hstate_o[HS_TLZ] && !pstate_o[PS_AM]));

   p_window_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (32'(cwp_o) < NWIN));
endmodule

bind trap_entry_unit trap_entry_unit_chk #(
   .NWIN(NWIN), .MAXTL(MAXTL), .MAXGL(MAXGL), .MAXPGL(MAXPGL)
) u_chk (
   .clk(clk), .rst_n(rst_n), .take_i(take_i), .to_hyper_i(to_hyper_i),
   .red_i(red_i), .tl_i(tl_i), .done_o(done_o), .tl_o(tl_o), .gl_o(gl_o),
   .pstate_o(pstate_o), .hstate_o(hstate_o), .cwp_o(cwp_o)
);

// File: tb/trap_entry_unit_tb.sv
module trap_entry_unit_tb_top;
   localparam int CLK_PERIOD = 20;
   localparam int NWIN   = 8;
   localparam int MAXTL  = 6;
   localparam int MAXGL  = 3;
   localparam int MAXPGL = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        take_i = 1'b0;
   logic [8:0]  ttype_i = '0;
   logic        to_hyper_i = 1'b0;
   logic        red_i = 1'b0;
   logic [2:0]  tl_i = '0;
   logic [1:0]  gl_i = '0;
   logic [7:0]  ccr_i = '0;
   logic [7:0]  asi_i = '0;
   logic [12:0] pstate_i = '0;
   logic [11:0] hstate_i = '0;
   logic [2:0]  cwp_i = '0;
   logic [2:0]  cansave_i = '0;
   logic [63:0] pc_i = '0;
   logic [63:0] npc_i = '0;
   logic        done_o;
   logic [2:0]  tl_o;
   logic [1:0]  gl_o;
   logic [12:0] pstate_o;
   logic [11:0] hstate_o;
   logic [2:0]  cwp_o;
   logic [2:0]  rd_lvl_i = '0;
   logic [42:0] rd_tstate_o;
   logic [63:0] rd_tpc_o;
   logic [63:0] rd_tnpc_o;
   logic [11:0] rd_htstate_o;
   logic [8:0]  rd_tt_o;

   int errors = 0;
   int checks = 0;

   logic [42:0] m_ts [1:MAXTL];
   logic [63:0] m_pc [1:MAXTL];
   logic [63:0] m_np [1:MAXTL];
   logic [11:0] m_hs [1:MAXTL];
   logic [8:0]  m_tt [1:MAXTL];

   trap_entry_unit #(.NWIN(NWIN), .MAXTL(MAXTL), .MAXGL(MAXGL), .MAXPGL(MAXPGL)) dut_i (
      .clk(clk), .rst_n(rst_n), .take_i(take_i), .ttype_i(ttype_i),
      .to_hyper_i(to_hyper_i), .red_i(red_i), .tl_i(tl_i), .gl_i(gl_i),
      .ccr_i(ccr_i), .asi_i(asi_i), .pstate_i(pstate_i), .hstate_i(hstate_i),
      .cwp_i(cwp_i), .cansave_i(cansave_i), .pc_i(pc_i), .npc_i(npc_i),
      .done_o(done_o), .tl_o(tl_o), .gl_o(gl_o), .pstate_o(pstate_o),
      .hstate_o(hstate_o), .cwp_o(cwp_o), .rd_lvl_i(rd_lvl_i),
      .rd_tstate_o(rd_tstate_o), .rd_tpc_o(rd_tpc_o), .rd_tnpc_o(rd_tnpc_o),
      .rd_htstate_o(rd_htstate_o), .rd_tt_o(rd_tt_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [1:0] f_gl(input logic [1:0] gl, input bit red, input bit hyp);
      int cap = (red || hyp) ? MAXGL : MAXPGL;
      int n = int'(gl) + 1;
      return 2'((n > cap) ? cap : n);
   endfunction

   function automatic logic [12:0] f_ps(input logic [12:0] ps, input bit red, input bit hyp);
      logic [12:0] r;
      if (red) begin
         r = '0;
         r[2] = ps[2];
         r[4] = 1'b1;
      end else begin
         r = ps;
         r[4] = 1'b1;
         r[3] = 1'b0;
         r[1] = 1'b0;
         if (hyp) r[9] = 1'b0;
         else begin
            r[2] = 1'b1;
            r[9] = ps[8];
         end
      end
      return r;
   endfunction

   function automatic logic [11:0] f_hs(input logic [11:0] hs, input bit red, input bit hyp);
      logic [11:0] r = hs;
      if (red) begin
         r[5] = 1'b1; r[2] = 1'b1; r[10] = 1'b0; r[0] = 1'b0;
      end else if (hyp) begin
         r[5] = 1'b0; r[2] = 1'b1; r[10] = 1'b0;
      end
      return r;
   endfunction

   function automatic logic [2:0] f_cwp(input logic [8:0] tt, input logic [2:0] cwp,
                                        input logic [2:0] cs);
      int c = int'(cwp);
      if (tt == 9'h024)                       c = (c + 1) % NWIN;
      else if (tt >= 9'h080 && tt <= 9'h0BF)  c = (c + int'(cs) + 2) % NWIN;
      else if (tt >= 9'h0C0 && tt <= 9'h0FF)  c = (c + NWIN - 1) % NWIN;
      return 3'(c);
   endfunction

   function automatic logic [42:0] f_ts(input logic [1:0] gl, input logic [7:0] ccr,
                                        input logic [7:0] asi, input logic [12:0] ps,
                                        input logic [2:0] cwp);
      return {1'b0, gl, ccr, asi, 3'b000, ps, 3'b000, 2'b00, cwp};
   endfunction

   function automatic logic [63:0] f_mask(input logic [63:0] pc, input logic am);
      return am ? {32'h0, pc[31:0]} : pc;
   endfunction

   task automatic sweep_stack();
      for (int l = 1; l <= MAXTL; l++) begin
         rd_lvl_i = 3'(l);
         #1;
         chk("R2", $sformatf("tstate lvl%0d", l), 64'(rd_tstate_o), 64'(m_ts[l]));
         chk("R2", $sformatf("tt lvl%0d", l), 64'(rd_tt_o), 64'(m_tt[l]));
         chk("R3", $sformatf("tpc lvl%0d", l), rd_tpc_o, m_pc[l]);
         chk("R3", $sformatf("tnpc lvl%0d", l), rd_tnpc_o, m_np[l]);
         chk("R4", $sformatf("htstate lvl%0d", l), 64'(rd_htstate_o), 64'(m_hs[l]));
      end
   endtask

   task automatic trap(input logic [8:0] tt, input bit hyp, input bit red,
                       input logic [2:0] tl, input logic [1:0] gl,
                       input logic [7:0] ccr, input logic [7:0] asi,
                       input logic [12:0] ps, input logic [11:0] hs,
                       input logic [2:0] cwp, input logic [2:0] cs,
                       input logic [63:0] pc, input logic [63:0] npc);
      string preq;
      logic [2:0] held_tl;
      @(negedge clk);
      ttype_i = tt; to_hyper_i = hyp; red_i = red; tl_i = tl; gl_i = gl;
      ccr_i = ccr; asi_i = asi; pstate_i = ps; hstate_i = hs; cwp_i = cwp;
      cansave_i = cs; pc_i = pc; npc_i = npc; take_i = 1'b1;
      @(negedge clk);
      take_i = 1'b0;
      preq = red ? "R9" : (hyp ? "R6/R7" : "R6/R8");
      chk("R1", "done pulse", 64'(done_o), 64'd1);
      chk("R1", "tl_o", 64'(tl_o), 64'(tl + 3'd1));
      chk("R5", "gl_o", 64'(gl_o), 64'(f_gl(gl, red, hyp)));
      chk(preq, "pstate_o", 64'(pstate_o), 64'(f_ps(ps, red, hyp)));
      chk(red ? "R9" : (hyp ? "R7" : "R8"), "hstate_o", 64'(hstate_o), 64'(f_hs(hs, red, hyp)));
      chk("R10", "cwp_o", 64'(cwp_o), 64'(f_cwp(tt, cwp, cs)));
      m_ts[int'(tl)+1] = f_ts(gl, ccr, asi, ps, cwp);
      m_pc[int'(tl)+1] = f_mask(pc, ps[3]);
      m_np[int'(tl)+1] = f_mask(npc, ps[3]);
      m_hs[int'(tl)+1] = hs;
      m_tt[int'(tl)+1] = tt;
      sweep_stack();
      held_tl = tl_o;
      // scramble inputs without a strobe: outputs must hold
      tl_i = ~tl_i; pstate_i = ~pstate_i; cwp_i = ~cwp_i;
      @(negedge clk);
      chk("R1", "done low after pulse", 64'(done_o), 64'd0);
      chk("R1", "tl_o held", 64'(tl_o), 64'(held_tl));
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      for (int l = 1; l <= MAXTL; l++) begin
         m_ts[l] = '0; m_pc[l] = '0; m_np[l] = '0; m_hs[l] = '0; m_tt[l] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: reset state
      chk("R11", "done reset", 64'(done_o), 64'd0);
      chk("R11", "tl reset", 64'(tl_o), 64'd0);
      chk("R11", "pstate reset", 64'(pstate_o), 64'd0);
      chk("R11", "cwp reset", 64'(cwp_o), 64'd0);
      for (int l = 0; l <= MAXTL; l++) begin
         rd_lvl_i = 3'(l);
         #1;
         chk("R11", $sformatf("stack zero lvl%0d", l),
             64'(rd_tstate_o) | rd_tpc_o | rd_tnpc_o | 64'(rd_htstate_o) | 64'(rd_tt_o), 64'd0);
      end

      // directed corners
      trap(9'h024, 1'b0, 1'b0, 3'd0, 2'd0, 8'hA5, 8'h3C, 13'h1F0F, 12'hFFF, 3'd7, 3'd0,
           64'hDEAD_BEEF_0000_1000, 64'hDEAD_BEEF_0000_1004);              // R10 inc wrap, R3 mask
      trap(9'h0BF, 1'b1, 1'b0, 3'd1, 2'd3, 8'h01, 8'h80, 13'h0000, 12'h421, 3'd6, 3'd7,
           64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF4);              // R10 spill high wrap
      trap(9'h080, 1'b0, 1'b0, 3'd2, 2'd3, 8'hFF, 8'h00, 13'h0100, 12'h000, 3'd0, 3'd0,
           64'hFFFF_FFFF_FFFF_FFFC, 64'h0);                                  // R5 priv cap from 3
      trap(9'h0C0, 1'b1, 1'b1, 3'd3, 2'd2, 8'h5A, 8'h14, 13'h1FFF, 12'hFFF, 3'd0, 3'd3,
           64'h8000_0000_0000_0000, 64'h8000_0000_0000_0004);              // R9 overrides hyper, fill wrap
      trap(9'h1A4, 1'b0, 1'b0, 3'd4, 2'd1, 8'h0F, 8'hF0, 13'h0108, 12'h001, 3'd3, 3'd5,
           64'hCAFE_0000_1234_5678, 64'hCAFE_0000_1234_567C);              // R10 ninth bit set: no move, R3 am
      trap(9'h1C5, 1'b1, 1'b0, 3'd5, 2'd3, 8'h77, 8'h88, 13'h0302, 12'h405, 3'd5, 3'd2,
           64'h0000_0001_0000_0000, 64'h0000_0001_0000_0004);              // R2 top level, R7

      // constrained random traps
      for (int i = 0; i < 300; i++) begin
         logic [8:0] tt;
         int cls = int'($urandom % 5);
         case (cls)
            0: tt = 9'h024;
            1: tt = 9'h080 + 9'($urandom % 64);
            2: tt = 9'h0C0 + 9'($urandom % 64);
            default: tt = 9'($urandom);
         endcase
         trap(tt, 1'($urandom), (($urandom % 6) == 0),
              3'($urandom % MAXTL), 2'($urandom), 8'($urandom), 8'($urandom),
              13'($urandom), 12'($urandom), 3'($urandom), 3'($urandom),
              {$urandom, $urandom}, {$urandom, $urandom});
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule